// File: doc/BRIEF.md
# Inbound Window Match and Address Translation

This block decides what happens to each request that arrives from the serial link. It compares the request address against a bank of address windows. Each window has a base address and a size mask. A request that falls in no enabled window is rejected. A request that falls in window 0 is always sent to the local application-register space, and the response carries the offset of the request inside window 0. A request that falls in any other window is accepted and translated to a local memory address by the rule `local = incoming - translation_start + translation_offset`.

Windows are programmed through a small write port. The base and the size of a window share one register code, and a selector bit picks which of the two a write updates. A written size mask is rounded up to a power of two of at least 4 KB. A mask of zero turns the window off. The response is registered and appears one clock after the request strobe.

Top module: `inb_xlat`

## Requirements
- R1: While reset is held and until the first request after reset, `rsp_valid`, `rsp_accept`, `rsp_regspace` and `rsp_addr` are all zero.
- R2: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high, including back-to-back requests.
- R3: A request that matches no enabled window gives `rsp_accept`=0, `rsp_regspace`=0 and `rsp_addr`=0.
- R4: Window w matches address A when its mask M is non-zero and `(A & ~M) == (base & ~M)`. A matching request gives `rsp_accept`=1.
- R5: A request granted to window 0 gives `rsp_regspace`=1 and `rsp_addr = A & M0`. The translation start and offset of window 0 have no effect.
- R6: A request granted to window w>0 gives `rsp_regspace`=0 and `rsp_addr = A - start_w + offset_w`, modulo 2^32.
- R7: When several windows match, the lowest-numbered window is granted.
- R8: A write with `cfg_reg`=0 updates the base when `cfg_alt`=0 and the size mask when `cfg_alt`=1, and leaves the other field unchanged. `cfg_reg`=1 writes the translation start and `cfg_reg`=2 writes the translation offset.
- R9: A non-zero written mask with highest set bit p is stored as 2^(max(p,11)+1)-1, so every window is a power of two of at least 4 KB.
- R10: Writing a mask of zero disables the window, and it then matches nothing.
- R11: Writes with `cfg_reg`=3, or with `cfg_win` at or above the window count, change no window.
- R12: An address one byte beyond the top of a window, or one byte below its base, does not match that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Incoming request strobe |
| req_addr | input | 32 | Incoming request address |
| cfg_we | input | 1 | Configuration write enable |
| cfg_win | input | 3 | Window index of the write |
| cfg_reg | input | 2 | Register code: 0 window, 1 start, 2 offset, 3 reserved |
| cfg_alt | input | 1 | With code 0: 0 writes the base, 1 writes the mask |
| cfg_data | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one clock after the request |
| rsp_accept | output | 1 | 1 = request accepted |
| rsp_regspace | output | 1 | 1 = routed to application registers |
| rsp_addr | output | 32 | Local address, or offset inside window 0 |

## Verification
A corrupted base or mask register shows up as a wrong accept decision on the first request that lands near that window's edges. For this reason the sweep probes each window one byte inside and one byte outside both ends. A faulty priority pick or a bad translation register shows up as a wrong `rsp_addr` on the very next response, because every response is compared against an arithmetic model. A register file that takes reserved writes is caught by repeating the same probes after those writes.

// File: rtl/inb_xlat_pkg.sv
package inb_xlat_pkg;

  localparam int unsigned ADDR_W = 32;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    CFG_WINDOW = 2'd0,
    CFG_XSTART = 2'd1,
    CFG_XOFFS  = 2'd2,
    CFG_RSVD   = 2'd3
  } cfg_reg_e;

  typedef struct packed {
    addr_t base;
    addr_t mask;
    addr_t xstart;
    addr_t xoffs;
  } win_cfg_t;

  // Round a raw mask up to a contiguous low mask of at least 2^min_log2 bytes.
  function automatic addr_t norm_mask(addr_t raw, int unsigned min_log2);
    addr_t m;
    logic  seen;
    m    = '0;
    seen = 1'b0;
    for (int i = ADDR_W - 1; i >= 0; i--) begin
      if (raw[i]) seen = 1'b1;
      if (seen)   m[i] = 1'b1;
    end
    if (seen) begin
      for (int i = 0; i < ADDR_W; i++) begin
        if (i < int'(min_log2)) m[i] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/inb_win_regs.sv
module inb_win_regs
  import inb_xlat_pkg::*;
#(
  parameter int unsigned NUM_WIN  = 6,
  parameter int unsigned MIN_LOG2 = 12,
  localparam int unsigned IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_win,
  input  logic [1:0]       cfg_reg,
  input  logic             cfg_alt,
  input  addr_t            cfg_data,
  output win_cfg_t         win_q [NUM_WIN]
);

  cfg_reg_e reg_code;
  assign reg_code = cfg_reg_e'(cfg_reg);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic     sel;
    win_cfg_t nxt;

    assign sel = cfg_we && (cfg_win == IDX_W'(w));

    always_comb begin
      nxt = win_q[w];
      case (reg_code)
        CFG_WINDOW: begin
          if (cfg_alt) nxt.mask = norm_mask(cfg_data, MIN_LOG2);
          else         nxt.base = cfg_data;
        end
        CFG_XSTART: nxt.xstart = cfg_data;
        CFG_XOFFS:  nxt.xoffs  = cfg_data;
        default:    ;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_q[w] <= '0;
      end else if (sel) begin
        win_q[w] <= nxt;
      end
    end
  end

endmodule

// File: rtl/inb_win_match.sv
module inb_win_match
  import inb_xlat_pkg::*;
#(
  parameter int unsigned NUM_WIN = 6
) (
  input  addr_t              addr,
  input  win_cfg_t           win_q [NUM_WIN],
  output logic [NUM_WIN-1:0] hit
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic  enabled;
    addr_t keep;
    assign enabled = |win_q[w].mask;
    assign keep    = ~win_q[w].mask;
    assign hit[w]  = enabled && ((addr & keep) == (win_q[w].base & keep));
  end

endmodule

// File: rtl/inb_win_pick.sv
module inb_win_pick #(
  parameter int unsigned NUM_WIN = 6
) (
  input  logic [NUM_WIN-1:0] hit,
  output logic [NUM_WIN-1:0] grant,
  output logic               any
);

  always_comb begin
    logic found;
    grant = '0;
    found = 1'b0;
    for (int w = 0; w < int'(NUM_WIN); w++) begin
      if (hit[w] && !found) begin
        grant[w] = 1'b1;
        found    = 1'b1;
      end
    end
    any = found;
  end

endmodule

// File: rtl/inb_xlat.sv
module inb_xlat
  import inb_xlat_pkg::*;
#(
  parameter int unsigned NUM_WIN  = 6,
  parameter int unsigned MIN_LOG2 = 12,
  localparam int unsigned IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [31:0]      req_addr,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_win,
  input  logic [1:0]       cfg_reg,
  input  logic             cfg_alt,
  input  logic [31:0]      cfg_data,
  output logic             rsp_valid,
  output logic             rsp_accept,
  output logic             rsp_regspace,
  output logic [31:0]      rsp_addr
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  win_cfg_t           win_q [NUM_WIN];
  logic [NUM_WIN-1:0] hit;
  logic [NUM_WIN-1:0] grant;
  logic               any;

  inb_win_regs #(.NUM_WIN(NUM_WIN), .MIN_LOG2(MIN_LOG2)) u_regs (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .cfg_we   (cfg_we),
    .cfg_win  (cfg_win),
    .cfg_reg  (cfg_reg),
    .cfg_alt  (cfg_alt),
    .cfg_data (cfg_data),
    .win_q    (win_q)
  );

  inb_win_match #(.NUM_WIN(NUM_WIN)) u_match (
    .addr  (req_addr),
    .win_q (win_q),
    .hit   (hit)
  );

  inb_win_pick #(.NUM_WIN(NUM_WIN)) u_pick (
    .hit   (hit),
    .grant (grant),
    .any   (any)
  );

  // Next-state computation.
  win_cfg_t sel_cfg;
  logic     nxt_accept;
  logic     nxt_regspace;
  addr_t    nxt_addr;
  logic     out_en;

  always_comb begin
    sel_cfg = '0;
    for (int w = 0; w < int'(NUM_WIN); w++) begin
      if (grant[w]) sel_cfg = win_q[w];
    end
    nxt_accept   = req_valid && any;
    nxt_regspace = nxt_accept && grant[0];
    if (!nxt_accept)       nxt_addr = '0;
    else if (grant[0])     nxt_addr = req_addr & sel_cfg.mask;
    else                   nxt_addr = req_addr - sel_cfg.xstart + sel_cfg.xoffs;
    out_en = req_valid || rsp_valid;
  end

  // Response registers.
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_accept   <= 1'b0;
      rsp_regspace <= 1'b0;
      rsp_addr     <= '0;
    end else if (out_en) begin
      rsp_accept   <= nxt_accept;
      rsp_regspace <= nxt_regspace;
      rsp_addr     <= nxt_addr;
    end
  end

endmodule

// File: rtl/inb_xlat_chk.sv
module inb_xlat_chk #(
  parameter int unsigned NUM_WIN = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               rsp_valid,
  input logic               rsp_accept,
  input logic               rsp_regspace,
  input logic [31:0]        rsp_addr,
  input logic [NUM_WIN-1:0] grant
);

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_reject_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_accept) |-> (!rsp_regspace && rsp_addr == 32'd0));

  p_accept_in_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_accept |-> rsp_valid);

  p_regspace_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_regspace |-> rsp_accept);

  p_single_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

endmodule

bind inb_xlat inb_xlat_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .req_valid    (req_valid),
  .rsp_valid    (rsp_valid),
  .rsp_accept   (rsp_accept),
  .rsp_regspace (rsp_regspace),
  .rsp_addr     (rsp_addr),
  .grant        (grant)
);

// File: tb/inb_xlat_test.sv
module inb_xlat_test;

  localparam int NW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_win = '0;
  logic [1:0]  cfg_reg = '0;
  logic        cfg_alt = 1'b0;
  logic [31:0] cfg_data = '0;
  logic        rsp_valid, rsp_accept, rsp_regspace;
  logic [31:0] rsp_addr;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_base [NW];
  logic [31:0] m_mask [NW];
  logic [31:0] m_xs   [NW];
  logic [31:0] m_xo   [NW];

  always #2.5 clk = ~clk;   // 200 MHz

  inb_xlat #(.NUM_WIN(NW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_reg(cfg_reg), .cfg_alt(cfg_alt),
    .cfg_data(cfg_data), .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
    .rsp_regspace(rsp_regspace), .rsp_addr(rsp_addr)
  );

  function automatic logic [31:0] size_of(logic [31:0] raw);
    int p;
    longint v;
    if (raw == 0) return 32'd0;
    p = 31;
    while (!raw[p]) p--;
    if (p < 11) p = 11;
    v = (64'd1 << (p + 1)) - 1;
    return v[31:0];
  endfunction

  task automatic cfg_write(input int w, input int r, input logic alt, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = 3'(w); cfg_reg = 2'(r); cfg_alt = alt; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    // Model update for legal writes only (R8, R9, R11).
    if (w < NW) begin
      case (r)
        0: if (alt) m_mask[w] = size_of(d); else m_base[w] = d;
        1: m_xs[w] = d;
        2: m_xo[w] = d;
        default: ;
      endcase
    end
  endtask

  task automatic model(input logic [31:0] a, output logic acc, output logic rs,
                       output logic [31:0] la, output string tag);
    acc = 0; rs = 0; la = 0; tag = "R3";
    for (int w = 0; w < NW; w++) begin
      if (!acc && m_mask[w] != 0 && ((a & ~m_mask[w]) == (m_base[w] & ~m_mask[w]))) begin
        acc = 1;
        if (w == 0) begin rs = 1; la = a & m_mask[w]; tag = "R5"; end
        else        begin la = a - m_xs[w] + m_xo[w]; tag = "R6"; end
      end
    end
  endtask

  task automatic check_rsp(input logic [31:0] a, input string note);
    logic acc, rs;
    logic [31:0] la;
    string tag;
    model(a, acc, rs, la, tag);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_accept !== acc || rsp_regspace !== rs || rsp_addr !== la) begin
      fails++;
      $display("FAIL %s/%s addr=%h actual v=%b acc=%b rs=%b la=%h expected v=1 acc=%b rs=%b la=%h",
               tag, note, a, rsp_valid, rsp_accept, rsp_regspace, rsp_addr, acc, rs, la);
    end
  endtask

  task automatic probe(input logic [31:0] a, input string note);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(a, note);
  endtask

  task automatic probe_edges(input int w, input string note);
    logic [31:0] lo, hi;
    lo = m_base[w] & ~m_mask[w];
    hi = lo + m_mask[w];
    probe(lo, note);
    probe(hi, note);
    probe(lo - 1, "R12");
    probe(hi + 1, "R12");
    probe(lo + (m_mask[w] >> 1), note);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    for (int w = 0; w < NW; w++) begin
      m_base[w] = 0; m_mask[w] = 0; m_xs[w] = 0; m_xo[w] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    checks++;
    if ({rsp_valid, rsp_accept, rsp_regspace} !== 3'b000 || rsp_addr !== 0) begin
      fails++;
      $display("FAIL R1 in reset actual %b%b%b %h expected 000 0", rsp_valid, rsp_accept, rsp_regspace, rsp_addr);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if ({rsp_valid, rsp_accept, rsp_regspace} !== 3'b000 || rsp_addr !== 0) begin
      fails++;
      $display("FAIL R1 after reset actual %b%b%b %h expected 000 0", rsp_valid, rsp_accept, rsp_regspace, rsp_addr);
    end

    // R10: all windows disabled after reset
    probe(32'h0000_0000, "R10");
    probe(32'h6000_0000, "R10");
    probe(32'hFFFF_FFFF, "R10");

    // Programming (R8, R9)
    cfg_write(0, 0, 0, 32'h6000_0000);
    cfg_write(0, 0, 1, 32'h0000_0FFF);
    cfg_write(0, 1, 0, 32'h1234_5000);   // R5: ignored for window 0
    cfg_write(0, 2, 0, 32'h0BAD_0000);
    cfg_write(1, 0, 0, 32'h6010_0000);
    cfg_write(1, 0, 1, 32'h000F_0000);   // R9: rounds to 1 MB
    cfg_write(1, 1, 0, 32'h6010_0000);
    cfg_write(1, 2, 0, 32'h0C00_0000);
    cfg_write(2, 0, 0, 32'h9000_0000);
    cfg_write(2, 0, 1, 32'h0000_0100);   // R9: raised to 4 KB
    cfg_write(2, 1, 0, 32'h9000_0000);
    cfg_write(2, 2, 0, 32'h8000_0000);
    cfg_write(3, 0, 0, 32'h6010_0000);
    cfg_write(3, 0, 1, 32'h001F_FFFF);   // R7: overlaps windows 0 and 1
    cfg_write(3, 1, 0, 32'h6000_0000);
    cfg_write(3, 2, 0, 32'h8000_0000);
    cfg_write(4, 0, 0, 32'h4000_0000);   // R10: base only, mask stays zero
    cfg_write(4, 2, 0, 32'h0000_1000);
    cfg_write(5, 0, 0, 32'hFFFF_F000);
    cfg_write(5, 0, 1, 32'h0000_0800);
    cfg_write(5, 1, 0, 32'hFFFF_F000);
    cfg_write(5, 2, 0, 32'h0000_0010);

    for (int w = 0; w < NW; w++) if (m_mask[w] != 0) probe_edges(w, "R4");
    probe(32'h4000_0000, "R10");
    // R7: sweep across the overlapping region
    for (int a = 32'h5FFF_0000; a < 32'h6030_0000; a += 32'h0001_0800) probe(32'(a), "R7");
    // R6: dense sweep through window 2 and past its top
    for (int a = 0; a < 32'h1400; a += 32'h100) probe(32'h9000_0000 + 32'(a), "R6");

    // R2: back-to-back requests
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a;
      a = 32'h6000_0000 + 32'(i) * 32'h0004_0100;
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      check_rsp(a, "R2");
    end
    req_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R2 idle actual %b expected 0", rsp_valid);
    end

    // R11: reserved code and out-of-range window
    cfg_write(2, 3, 0, 32'hDEAD_BEEF);
    cfg_write(2, 3, 1, 32'h0000_0000);
    cfg_write(6, 0, 1, 32'h0000_0000);
    cfg_write(7, 0, 0, 32'h0000_0000);
    probe_edges(2, "R11");
    probe(32'hFFFF_F800, "R11");

    // R8: base rewrite keeps mask
    cfg_write(2, 0, 0, 32'hA000_0000);
    cfg_write(2, 1, 0, 32'hA000_0000);
    probe_edges(2, "R8");
    probe(32'h9000_0010, "R8");

    // R10 + R7: disable window 1, window 3 takes over
    cfg_write(1, 0, 1, 32'h0000_0000);
    probe(32'h6010_0000, "R10");
    probe(32'h601F_FFFF, "R10");
    probe(32'h6000_0FFF, "R7");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule